// File: doc/BRIEF.md
# UART FIFO Interrupt and Ready Signalling

This block turns the fill state of a UART's receive and transmit FIFOs into the
two interrupt requests and the two active-low ready handshakes that a host CPU
or a DMA engine watches. It does not hold any data itself: the FIFO occupancy
counts, the trigger thresholds, the receive character-timeout pulse and the host
access strobes all arrive as inputs, and every output is registered so that it
changes on the clock edge after the event that causes it.

Two behaviours set it apart from a plain threshold compare. In DMA mode the
receive ready line has hysteresis: once the receive FIFO reaches its trigger
(or a timeout fires with data waiting) the line stays low until the FIFO has been
drained completely, whereas the receive interrupt follows the threshold directly.
The transmit interrupt is an event flag raised when the transmit FIFO runs dry,
and it is withdrawn either by a status-register read or by the host refilling the
FIFO up to its trigger, whichever comes first. The host read and write strobes
can be wired either active-high or active-low; a leading-edge detector makes one
access out of each strobe pulse, however long it is held, with the same timing
for both polarities.

Top module: `uart_irq_ready`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs go to `rx_irq`=0, `tx_irq`=0, `rxrdy_n`=1, `txrdy_n`=1.
- R2: One cycle after `rx_level` >= `rx_trig` with `ien_rx`=1, `rx_irq` is 1; once the level falls below the trigger (and no timeout is pending) it returns to 0 one cycle later; with `ien_rx`=0 it is 0.
- R3: A one-cycle `rx_char_timeout` pulse while `rx_level` is nonzero raises `rx_irq` one cycle later even below the trigger, and it stays raised; a pulse while `rx_level` is zero has no effect on `rx_irq` or `rxrdy_n`.
- R4: A pending timeout interrupt is withdrawn one cycle after the leading edge of a host read with `rd_sel_status`=0 (data register); a read with `rd_sel_status`=1 (status register) leaves it pending.
- R5: With `dma_mode`=0, `rxrdy_n` is 0 one cycle after `rx_level` is nonzero and 1 one cycle after it is zero.
- R6: With `dma_mode`=1, `rxrdy_n` goes to 0 one cycle after `rx_level` reaches `rx_trig` or after a timeout pulse with data present, and returns to 1 only one cycle after `rx_level` is zero.
- R7: With `ien_tx`=1, `tx_irq` rises one cycle after `tx_level` changes from nonzero to zero and stays high; with `ien_tx`=0 it is 0.
- R8: A pending `tx_irq` is withdrawn one cycle after the leading edge of a host read with `rd_sel_status`=1.
- R9: A pending `tx_irq` is withdrawn one cycle after `tx_level` reaches `tx_trig`.
- R10: With `dma_mode`=0, `txrdy_n` is 0 while `tx_level` is zero and goes to 1 one cycle after the leading edge of a host write, staying 1 while `tx_level` is nonzero.
- R11: With `dma_mode`=1, `txrdy_n` is 0 one cycle after `tx_level` < `tx_trig` and 1 one cycle after `tx_level` >= `tx_trig`.
- R12: With `strobe_active_high`=1 a strobe is active when high, with 0 when low; both give the same one-cycle response, and a strobe held active for several cycles counts as one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_active_high | input | 1 | 1: host strobes active high, 0: active low |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe to the transmit data register |
| rd_sel_status | input | 1 | Read target: 0 receive data register, 1 interrupt status register |
| rx_level | input | CW | Receive FIFO occupancy |
| tx_level | input | CW | Transmit FIFO occupancy |
| rx_trig | input | CW | Receive trigger level (1..DEPTH) |
| tx_trig | input | CW | Transmit trigger level (1..DEPTH) |
| rx_char_timeout | input | 1 | One-cycle receive character-timeout pulse |
| ien_rx | input | 1 | Receive interrupt enable |
| ien_tx | input | 1 | Transmit interrupt enable |
| dma_mode | input | 1 | Ready signals in DMA (threshold) mode |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |

## Verification
The hardest state to reach is a timeout interrupt that is still pending while a data-register read strobe is held low across several cycles and a second timeout arrives during that hold: only then does it show whether a long strobe is counted once and whether a new timeout survives it. The bench reaches it by selecting active-low strobes, raising a timeout below the trigger, asserting the read and, two cycles into the hold, pulsing the timeout again. The threshold behaviour is covered by sweeping every trigger against every occupancy of an eight-entry configuration, ramping up and down in DMA mode to expose the hysteresis.

// File: rtl/uirq_pkg.sv
// Shared types for the UART interrupt / ready block.
// Assumes: nothing beyond IEEE 1800-2017.
package uirq_pkg;

    // Target of a host read access, as decoded from rd_sel_status.
    typedef enum logic {
        RD_DATA   = 1'b0,
        RD_STATUS = 1'b1
    } rd_target_e;

    // Index of each host strobe in the strobe edge array.
    localparam int STB_RD = 0;
    localparam int STB_WR = 1;
    localparam int NUM_STB = 2;

endpackage

// File: rtl/uirq_strobe_edge.sv
// Converts a host strobe of selectable polarity into a one-cycle access
// event on its leading edge. Assumes the strobe is synchronous to clk and
// that the polarity select only changes while the strobe is idle.
module uirq_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic active_high,
    input  logic raw,
    output logic access_o
);
    logic act;
    logic act_q;

    // Normalise the strobe to active-high.
    assign act = active_high ? raw : ~raw;

    // Remember last cycle's level; reset as "active" so no event at release.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b1;
        else        act_q <= act;
    end

    assign access_o = act & ~act_q;
endmodule

// File: rtl/uirq_rx_path.sv
// Receive side: threshold/timeout interrupt and the receive ready line.
// Assumes trig is in 1..DEPTH and timeout is a single-cycle pulse.
module uirq_rx_path #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trig,
    input  logic          timeout,
    input  logic          data_rd,
    input  logic          ien,
    input  logic          dma,
    output logic          irq,
    output logic          rdy_n
);
    logic at_trig, has_data;
    logic to_q, to_d;
    logic hold_q, hold_d;

    assign at_trig  = (level >= trig);
    assign has_data = (level != '0);

    // Timeout flag: a new timeout with data wins over a data read.
    always_comb begin
        if (timeout && has_data) to_d = 1'b1;
        else if (data_rd)        to_d = 1'b0;
        else                     to_d = to_q;
    end

    // DMA hysteresis: set at trigger or timeout, release only when empty.
    always_comb begin
        if (!has_data)                hold_d = 1'b0;
        else if (at_trig || timeout)  hold_d = 1'b1;
        else                          hold_d = hold_q;
    end

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q   <= 1'b0;
            hold_q <= 1'b0;
            irq    <= 1'b0;
            rdy_n  <= 1'b1;
        end else begin
            to_q   <= to_d;
            hold_q <= hold_d;
            irq    <= ien & (at_trig | to_d);
            rdy_n  <= dma ? ~hold_d : ~has_data;
        end
    end
endmodule

// File: rtl/uirq_tx_path.sv
// Transmit side: empty-event interrupt and the transmit ready line.
// Assumes trig is in 1..DEPTH; the FIFO count updates after a write.
module uirq_tx_path #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trig,
    input  logic          status_rd,
    input  logic          wr,
    input  logic          ien,
    input  logic          dma,
    output logic          irq,
    output logic          rdy_n
);
    logic empty, at_trig, became_empty;
    logic was_empty_q;
    logic flag_q, flag_d;

    assign empty        = (level == '0);
    assign at_trig      = (level >= trig);
    assign became_empty = empty & ~was_empty_q;

    // Empty event sets the flag; status read, refill or disable clears it.
    always_comb begin
        if (ien && became_empty)              flag_d = 1'b1;
        else if (!ien || status_rd || at_trig) flag_d = 1'b0;
        else                                  flag_d = flag_q;
    end

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_empty_q <= 1'b1;
            flag_q      <= 1'b0;
            irq         <= 1'b0;
            rdy_n       <= 1'b1;
        end else begin
            was_empty_q <= empty;
            flag_q      <= flag_d;
            irq         <= flag_d;
            rdy_n       <= dma ? at_trig : ~(empty & ~wr);
        end
    end
endmodule

// File: rtl/uart_irq_ready.sv
// Top of the UART interrupt / ready block: decodes host strobes into
// access events and drives the receive and transmit paths.
// Assumes all inputs are synchronous to clk and triggers lie in 1..DEPTH.
module uart_irq_ready #(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_active_high,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic          rd_sel_status,
    input  logic [CW-1:0] rx_level,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_trig,
    input  logic [CW-1:0] tx_trig,
    input  logic          rx_char_timeout,
    input  logic          ien_rx,
    input  logic          ien_tx,
    input  logic          dma_mode,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          rxrdy_n,
    output logic          txrdy_n
);
    import uirq_pkg::*;

    logic [NUM_STB-1:0] raw_stb;
    logic [NUM_STB-1:0] stb_ev;
    rd_target_e         rd_tgt;
    logic               data_rd, status_rd;

    assign raw_stb[STB_RD] = host_rd;
    assign raw_stb[STB_WR] = host_wr;

    // One edge detector per host strobe.
    for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
        uirq_strobe_edge u_edge (
            .clk         (clk),
            .rst_n       (rst_n),
            .active_high (strobe_active_high),
            .raw         (raw_stb[i]),
            .access_o    (stb_ev[i])
        );
    end

    assign rd_tgt    = rd_target_e'(rd_sel_status);
    assign data_rd   = stb_ev[STB_RD] & (rd_tgt == RD_DATA);
    assign status_rd = stb_ev[STB_RD] & (rd_tgt == RD_STATUS);

    uirq_rx_path #(.CW(CW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (rx_level),
        .trig    (rx_trig),
        .timeout (rx_char_timeout),
        .data_rd (data_rd),
        .ien     (ien_rx),
        .dma     (dma_mode),
        .irq     (rx_irq),
        .rdy_n   (rxrdy_n)
    );

    uirq_tx_path #(.CW(CW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (tx_level),
        .trig      (tx_trig),
        .status_rd (status_rd),
        .wr        (stb_ev[STB_WR]),
        .ien       (ien_tx),
        .dma       (dma_mode),
        .irq       (tx_irq),
        .rdy_n     (txrdy_n)
    );
endmodule

// File: rtl/uirq_checks.sv
// Port-level properties of uart_irq_ready, attached by bind.
// Assumes triggers lie in 1..DEPTH.
module uirq_checks #(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] rx_level,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_trig,
    input logic [CW-1:0] tx_trig,
    input logic          ien_rx,
    input logic          ien_tx,
    input logic          dma_mode,
    input logic          rx_irq,
    input logic          tx_irq,
    input logic          rxrdy_n,
    input logic          txrdy_n
);
    a_r2_at_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_rx && rx_level >= rx_trig) |=> rx_irq);

    a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_rx |=> !rx_irq);

    a_r5_plain_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode) |=> (rxrdy_n == ($past(rx_level) == '0)));

    a_r6_dma_set: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && rx_level >= rx_trig) |=> !rxrdy_n);

    a_r6_dma_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && rx_level == '0) |=> rxrdy_n);

    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_tx |=> !tx_irq);

    a_r9_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level >= tx_trig) |=> !tx_irq);

    a_r11_dma_tx: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode |=> (txrdy_n == ($past(tx_level) >= $past(tx_trig))));
endmodule

bind uart_irq_ready uirq_checks #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rx_trig  (rx_trig),
    .tx_trig  (tx_trig),
    .ien_rx   (ien_rx),
    .ien_tx   (ien_tx),
    .dma_mode (dma_mode),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq),
    .rxrdy_n  (rxrdy_n),
    .txrdy_n  (txrdy_n)
);

// File: tb/sim_uart_irq_ready.sv
`timescale 1ns/1ps
module sim_uart_irq_ready;
    localparam int DEPTH = 8;
    localparam int CW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strobe_active_high, host_rd, host_wr, rd_sel_status;
    logic [CW-1:0] rx_level, tx_level, rx_trig, tx_trig;
    logic          rx_char_timeout, ien_rx, ien_tx, dma_mode;
    logic          rx_irq, tx_irq, rxrdy_n, txrdy_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ready #(.DEPTH(DEPTH), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .strobe_active_high(strobe_active_high),
        .host_rd(host_rd), .host_wr(host_wr), .rd_sel_status(rd_sel_status),
        .rx_level(rx_level), .tx_level(tx_level), .rx_trig(rx_trig),
        .tx_trig(tx_trig), .rx_char_timeout(rx_char_timeout),
        .ien_rx(ien_rx), .ien_tx(ien_tx), .dma_mode(dma_mode),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    // Advance one clock; inputs are driven and outputs sampled at negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        rst_n = 1'b0; strobe_active_high = 1'b1; host_rd = 1'b0; host_wr = 1'b0;
        rd_sel_status = 1'b0; rx_level = '0; tx_level = '0; rx_trig = 4'd4;
        tx_trig = 4'd4; rx_char_timeout = 1'b0; ien_rx = 1'b1; ien_tx = 1'b1;
        dma_mode = 1'b0;
        @(negedge clk);
        step(); step();
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 tx_irq", tx_irq, 0);
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 txrdy_n", txrdy_n, 1);
        rst_n = 1'b1;
        step();

        // R2 / R5: every trigger against every occupancy, non-DMA.
        for (int t = 1; t <= DEPTH; t++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                rx_trig = 4'(t); rx_level = 4'(l);
                step();
                chk("R2 rx_irq level", rx_irq, (l >= t) ? 1 : 0);
                chk("R5 rxrdy_n plain", rxrdy_n, (l == 0) ? 1 : 0);
            end
        end
        ien_rx = 1'b0; rx_trig = 4'd1; rx_level = 4'd8;
        step();
        chk("R2 rx_irq disabled", rx_irq, 0);
        ien_rx = 1'b1; rx_level = '0;
        step();

        // R6: ramp up then down in DMA mode for every trigger.
        dma_mode = 1'b1;
        for (int t = 1; t <= DEPTH; t++) begin
            rx_trig = 4'(t);
            for (int l = 0; l <= DEPTH; l++) begin
                rx_level = 4'(l);
                step();
                chk("R6 rxrdy_n rising", rxrdy_n, (l >= t) ? 0 : 1);
            end
            for (int l = DEPTH; l >= 0; l--) begin
                rx_level = 4'(l);
                step();
                chk("R6 rxrdy_n falling", rxrdy_n, (l > 0) ? 0 : 1);
            end
        end

        // R3 / R6: timeout with data, below the trigger, DMA mode.
        rx_trig = 4'd6; rx_level = 4'd2;
        step();
        chk("R6 below trig no ready", rxrdy_n, 1);
        chk("R3 no irq before timeout", rx_irq, 0);
        rx_char_timeout = 1'b1;
        step();
        rx_char_timeout = 1'b0;
        chk("R3 rx_irq after timeout", rx_irq, 1);
        chk("R6 rxrdy_n after timeout", rxrdy_n, 0);
        rx_level = 4'd1;
        step();
        chk("R3 rx_irq held", rx_irq, 1);
        chk("R6 rxrdy_n held", rxrdy_n, 0);
        // R4: status read does not clear the timeout interrupt.
        rd_sel_status = 1'b1; host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        chk("R4 status read keeps rx_irq", rx_irq, 1);
        step();
        // R4: data read clears it.
        rd_sel_status = 1'b0; host_rd = 1'b1; rx_level = 4'd0;
        step();
        host_rd = 1'b0;
        chk("R4 data read clears rx_irq", rx_irq, 0);
        chk("R6 rxrdy_n empty release", rxrdy_n, 1);
        step();
        // R3: timeout with empty FIFO is ignored.
        rx_char_timeout = 1'b1;
        step();
        rx_char_timeout = 1'b0;
        chk("R3 empty timeout rx_irq", rx_irq, 0);
        chk("R3 empty timeout rxrdy_n", rxrdy_n, 1);

        // R12: active-low strobes, held read, second timeout during hold.
        dma_mode = 1'b0; strobe_active_high = 1'b0; host_rd = 1'b1; host_wr = 1'b1;
        rx_level = 4'd2;
        step();
        rx_char_timeout = 1'b1;
        step();
        rx_char_timeout = 1'b0;
        chk("R12 timeout irq low-pol", rx_irq, 1);
        host_rd = 1'b0;
        step();
        chk("R12 active-low read clears", rx_irq, 0);
        rx_char_timeout = 1'b1;
        step();
        rx_char_timeout = 1'b0;
        chk("R12 new timeout during hold", rx_irq, 1);
        step();
        chk("R12 held read counts once", rx_irq, 1);
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        step();
        host_rd = 1'b1;
        chk("R12 second low-pol read clears", rx_irq, 0);
        strobe_active_high = 1'b1; host_rd = 1'b0; host_wr = 1'b0; rx_level = '0;
        step();

        // R7 / R8 / R9: transmit interrupt.
        tx_trig = 4'd4; tx_level = 4'd3;
        step();
        chk("R7 no irq while filled", tx_irq, 0);
        tx_level = 4'd0;
        step();
        chk("R7 tx_irq on empty", tx_irq, 1);
        step();
        chk("R7 tx_irq held", tx_irq, 1);
        rd_sel_status = 1'b1; host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        chk("R8 status read clears tx_irq", tx_irq, 0);
        tx_level = 4'd2;
        step();
        tx_level = 4'd0;
        step();
        chk("R7 tx_irq second empty", tx_irq, 1);
        rd_sel_status = 1'b0; host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        chk("R8 data read keeps tx_irq", tx_irq, 1);
        tx_level = 4'd3;
        step();
        chk("R9 below trig keeps tx_irq", tx_irq, 1);
        tx_level = 4'd4;
        step();
        chk("R9 refill clears tx_irq", tx_irq, 0);
        ien_tx = 1'b0; tx_level = 4'd0;
        step();
        chk("R7 disabled tx_irq", tx_irq, 0);
        ien_tx = 1'b1;

        // R10: non-DMA transmit ready.
        chk("R10 txrdy_n empty", txrdy_n, 0);
        host_wr = 1'b1;
        step();
        chk("R10 txrdy_n after write", txrdy_n, 1);
        host_wr = 1'b0; tx_level = 4'd1;
        step();
        chk("R10 txrdy_n with data", txrdy_n, 1);
        tx_level = 4'd0;
        step();
        chk("R10 txrdy_n drained", txrdy_n, 0);
        // R12: active-low write strobe has same timing.
        strobe_active_high = 1'b0; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
        step();
        chk("R12 active-low write", txrdy_n, 1);
        host_wr = 1'b1;
        step();
        chk("R12 write released, empty", txrdy_n, 0);
        strobe_active_high = 1'b1; host_wr = 1'b0; host_rd = 1'b0;

        // R11: DMA transmit ready sweep.
        dma_mode = 1'b1;
        for (int t = 1; t <= DEPTH; t++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                tx_trig = 4'(t); tx_level = 4'(l);
                step();
                chk("R11 txrdy_n dma", txrdy_n, (l >= t) ? 1 : 0);
            end
        end

        summary();
    end
endmodule